// File: doc/BRIEF.md
# Hierarchical Instruction Chain Extender

This block holds the instruction register of one die in a stacked test wrapper and decides, at run time, whether the serial instruction chain also passes through the instruction register of a core embedded in that die. The die instruction has three fields. The first is an opcode. The second is a bit that bypasses the die's own top-level scan logic, so that the embedded core can be tested on its own. The third is a core-enable bit. While the core-enable bit is clear, the core register is held in its functional reset state and is left out of the chain. Once the bit is set, the core register sees the wrapper reset ungated and its serial path is spliced between the die register and the serial output.

A test sequence starts with a reset. After the reset the chain is at its shortest length and every instruction is zero. A load of the die register alone may follow, and that can be the whole configuration. If that load sets core-enable, the chain grows, and a second load then carries both the core instruction and the die instruction.

Top module: `hier_ir_chain`

## Requirements
- R1: A clock edge with `rst_n` low clears the opcode, bypass, core-enable and core instruction outputs. Afterwards `core_rst_n` and `so` are 0, and the chain has its short length.
- R2: With `sel_ir`=1 and `shift_en`=1, each clock moves `si` one place into the chain. `so` shows the last stage of the chain, and with core-enable clear the chain is OP_W+2 stages long (6 by default).
- R3: While core-enable is clear, `core_rst_n` is 0 and the core register ignores shifting. `core_op` reads 0 from the cycle after core-enable becomes clear.
- R4: A clock with `sel_ir`=1 and `update_en`=1 copies the die shift stage to the outputs. The opcode is bits [OP_W-1:0], bypass is bit OP_W and core-enable is bit OP_W+1. The bit shifted in last lands in bit OP_W+1. Without such a clock, the outputs hold.
- R5: Core-enable changes only at an update, so the chain length stays fixed for the whole of a shift operation.
- R6: With core-enable set, the chain is OP_W+2+CORE_W stages long, the core stage sits between the die stage and `so`, and an update also loads `core_op` from the core stage. The bit shifted in first ends in `core_op` bit 0.
- R7: A clock with `sel_ir`=1 and `capture_en`=1 loads each active shift stage with its current update value. Capture takes priority over shift.
- R8: With `sel_ir`=0, `shift_en`, `capture_en` and `update_en` have no effect on any output.
- R9: An update that clears core-enable returns the chain to the short length. `core_op` is cleared on the following clock.
- R10: `top_byp` follows bit OP_W of the updated die instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Synchronous active-low wrapper reset |
| sel_ir | input | 1 | Routes the serial controls to the instruction chain |
| shift_en | input | 1 | Shift the chain one place |
| capture_en | input | 1 | Load the shift stages from the update stages |
| update_en | input | 1 | Load the update stages from the shift stages |
| si | input | 1 | Serial instruction input |
| so | output | 1 | Serial instruction output |
| die_op | output | OP_W | Active die opcode |
| top_byp | output | 1 | Local bypass of die top-level scan logic |
| core_en | output | 1 | Core instruction register enabled |
| core_rst_n | output | 1 | Gated reset sent to the core register |
| core_op | output | CORE_W | Active core instruction |

## Verification
The assertions assume that `rst_n` is asserted for at least one clock before any check counts. They also assume that `sel_ir` qualifies every control, so control pulses with `sel_ir` low must be harmless. The stimulus therefore always starts with a reset. It raises capture, shift and update one at a time, except in one deliberate cycle where capture and shift are both high. It also pulses every control with `sel_ir` low while the instruction state is non-zero, so the hold properties are exercised against a state that could visibly change.

// File: rtl/hic_pkg.sv
// Shared types for the hierarchical instruction chain.
// Assumes all serial controls are synchronous to the test clock.
package hic_pkg;
    // Broadcast serial control bundle seen by every instruction stage
    typedef struct packed {
        logic sel;
        logic shift;
        logic capture;
        logic update;
    } ir_ctl_t;
endpackage

// File: rtl/ir_stage.sv
// One instruction register: shift stage plus update stage.
// Shifts right (new bit enters the MSB, LSB leaves on so).
// Capture reloads the shift stage from the update stage and wins over shift.
// Assumes rst_n is synchronous and active low.
module ir_stage #(
    parameter int W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  hic_pkg::ir_ctl_t ctl,
    input  logic            si,
    output logic            so,
    output logic [W-1:0]    upd
);
    logic [W-1:0] sr_q;
    logic [W-1:0] upd_q;

    // Shift stage: capture, shift or hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q <= '0;
        end else if (ctl.sel && ctl.capture) begin
            sr_q <= upd_q;
        end else if (ctl.sel && ctl.shift) begin
            if (W > 1) begin
                sr_q <= {si, sr_q[W-1:1]};
            end else begin
                sr_q <= si;
            end
        end
    end

    // Update stage: copy the shift stage on update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            upd_q <= '0;
        end else if (ctl.sel && ctl.update) begin
            upd_q <= sr_q;
        end
    end

    assign so  = sr_q[0];
    assign upd = upd_q;
endmodule

// File: rtl/ir_link.sv
// Chain splice and reset gate between die and core instruction stages.
// Selects the serial output tap and gates the wrapper reset with core-enable.
// Assumes core_en comes from an update stage, so it is stable while shifting.
module ir_link (
    input  logic rst_n,
    input  logic core_en,
    input  logic die_so,
    input  logic core_so,
    output logic so,
    output logic core_rst_n
);
    // Serial tap: include the core stage only when enabled
    always_comb begin
        so = core_en ? core_so : die_so;
    end

    // Reset gate: core stays in reset until enabled
    always_comb begin
        core_rst_n = rst_n & core_en;
    end
endmodule

// File: rtl/hier_ir_chain.sv
// Die-level instruction register with an optional embedded core register.
// Die instruction layout: [OP_W-1:0] opcode, [OP_W] top bypass, [OP_W+1] core enable.
// The core stage follows the die stage in the chain when enabled.
// Assumes a synchronous active-low reset and controls qualified by sel_ir.
module hier_ir_chain #(
    parameter int OP_W   = 4,
    parameter int CORE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_ir,
    input  logic              shift_en,
    input  logic              capture_en,
    input  logic              update_en,
    input  logic              si,
    output logic              so,
    output logic [OP_W-1:0]   die_op,
    output logic              top_byp,
    output logic              core_en,
    output logic              core_rst_n,
    output logic [CORE_W-1:0] core_op
);
    localparam int DIE_W   = OP_W + 2;
    localparam int BYP_BIT = OP_W;
    localparam int EN_BIT  = OP_W + 1;

    hic_pkg::ir_ctl_t ctl;
    logic             die_so;
    logic             core_so;
    logic [DIE_W-1:0] die_upd;
    logic             core_rst_int;

    // Broadcast controls pass to both stages unchanged
    always_comb begin
        ctl.sel     = sel_ir;
        ctl.shift   = shift_en;
        ctl.capture = capture_en;
        ctl.update  = update_en;
    end

    ir_stage #(.W(DIE_W)) i_die (
        .clk   (clk),
        .rst_n (rst_n),
        .ctl   (ctl),
        .si    (si),
        .so    (die_so),
        .upd   (die_upd)
    );

    ir_stage #(.W(CORE_W)) i_core (
        .clk   (clk),
        .rst_n (core_rst_int),
        .ctl   (ctl),
        .si    (die_so),
        .so    (core_so),
        .upd   (core_op)
    );

    ir_link i_link (
        .rst_n      (rst_n),
        .core_en    (die_upd[EN_BIT]),
        .die_so     (die_so),
        .core_so    (core_so),
        .so         (so),
        .core_rst_n (core_rst_int)
    );

    assign die_op     = die_upd[OP_W-1:0];
    assign top_byp    = die_upd[BYP_BIT];
    assign core_en    = die_upd[EN_BIT];
    assign core_rst_n = core_rst_int;
endmodule

// File: rtl/hic_checker.sv
// Property checker for hier_ir_chain, attached by bind below.
// Assumes rst_n is held low for at least one clock at start.
module hic_checker #(
    parameter int OP_W   = 4,
    parameter int CORE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel_ir,
    input logic              shift_en,
    input logic              capture_en,
    input logic              update_en,
    input logic              so,
    input logic [OP_W-1:0]   die_op,
    input logic              top_byp,
    input logic              core_en,
    input logic              core_rst_n,
    input logic [CORE_W-1:0] core_op
);
    logic rst_prev_q;

    // Post-reset state check one clock after a reset edge
    always_ff @(posedge clk) begin
        rst_prev_q <= !rst_n;
        if (rst_prev_q && rst_n) begin
            AST_RESET_STATE: assert (die_op == '0 && !top_byp && !core_en && !core_rst_n && core_op == '0 && !so); // R1
        end
    end

    AST_CORE_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |-> !core_rst_n); // R3

    AST_CORE_OP_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |=> core_op == '0); // R3

    AST_EN_AT_UPDATE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_ir && update_en) |=> $stable(core_en)); // R5

    AST_DIE_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_ir && update_en) |=> ($stable(die_op) && $stable(top_byp))); // R4

    AST_CORE_OP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && !(sel_ir && update_en)) |=> $stable(core_op)); // R6

    AST_IDLE_SO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_ir && (shift_en || capture_en || update_en)) |=> $stable(so)); // R8
endmodule

bind hier_ir_chain hic_checker #(.OP_W(OP_W), .CORE_W(CORE_W)) i_hic_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_ir     (sel_ir),
    .shift_en   (shift_en),
    .capture_en (capture_en),
    .update_en  (update_en),
    .so         (so),
    .die_op     (die_op),
    .top_byp    (top_byp),
    .core_en    (core_en),
    .core_rst_n (core_rst_n),
    .core_op    (core_op)
);

// File: tb/test_hier_ir_chain.sv
`timescale 1ns/1ps
// Bench for hier_ir_chain: behavioural reference compared every clock,
// plus directed checks of chain length and field contents.
module test_hier_ir_chain;
    localparam int OP_W   = 4;
    localparam int CORE_W = 3;
    localparam int DIE_W  = OP_W + 2;
    localparam int EN_B   = OP_W + 1;
    localparam int WD     = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0, sel_ir = 1'b0, shift_en = 1'b0, capture_en = 1'b0, update_en = 1'b0, si = 1'b0;
    logic so, top_byp, core_en, core_rst_n;
    logic [OP_W-1:0]   die_op;
    logic [CORE_W-1:0] core_op;

    int n_cmp = 0;
    int n_bad = 0;

    // Reference state: shift queues (index 0 nearest so) and active words
    bit m_dq[$];
    bit m_cq[$];
    logic [DIE_W-1:0]  m_dupd = '0;
    logic [CORE_W-1:0] m_cupd = '0;

    always #2 clk = ~clk;

    hier_ir_chain #(.OP_W(OP_W), .CORE_W(CORE_W)) i_hier_ir_chain (
        .clk(clk), .rst_n(rst_n), .sel_ir(sel_ir), .shift_en(shift_en),
        .capture_en(capture_en), .update_en(update_en), .si(si), .so(so),
        .die_op(die_op), .top_byp(top_byp), .core_en(core_en),
        .core_rst_n(core_rst_n), .core_op(core_op)
    );

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic logic [15:0] q2v(input bit q[$]);
        logic [15:0] v = '0;
        foreach (q[i]) v[i] = q[i];
        return v;
    endfunction

    // Compare every output against the reference
    task automatic compare(input string tag);
        bit exp_so = m_dupd[EN_B] ? m_cq[0] : m_dq[0];
        chk(so == exp_so, tag, "so", so, exp_so);
        chk(die_op == m_dupd[OP_W-1:0], tag, "die_op", die_op, m_dupd[OP_W-1:0]);
        chk(top_byp == m_dupd[OP_W], tag, "top_byp", top_byp, m_dupd[OP_W]);
        chk(core_en == m_dupd[EN_B], tag, "core_en", core_en, m_dupd[EN_B]);
        chk(core_rst_n == (rst_n && m_dupd[EN_B]), tag, "core_rst_n", core_rst_n, rst_n && m_dupd[EN_B]);
        chk(core_op == m_cupd, tag, "core_op", core_op, m_cupd);
    endtask

    // One clock: drive, advance the reference, sample at the falling edge
    task automatic step(input bit r, input bit s, input bit sh, input bit cp, input bit up, input bit d, input string tag);
        bit en = m_dupd[EN_B];
        bit d_out;
        logic [DIE_W-1:0]  dsr = q2v(m_dq);
        logic [CORE_W-1:0] csr = q2v(m_cq);
        rst_n = r; sel_ir = s; shift_en = sh; capture_en = cp; update_en = up; si = d;
        if (!r) begin
            foreach (m_dq[i]) m_dq[i] = 0;
            foreach (m_cq[i]) m_cq[i] = 0;
            m_dupd = '0; m_cupd = '0;
        end else begin
            d_out = m_dq[0];
            if (s && up) m_dupd = dsr;
            if (s && cp) begin
                foreach (m_dq[i]) m_dq[i] = m_dupd_prev(dsr, i, up && s);
            end else if (s && sh) begin
                void'(m_dq.pop_front()); m_dq.push_back(d);
            end
            if (!en) begin
                foreach (m_cq[i]) m_cq[i] = 0;
                m_cupd = '0;
            end else begin
                if (s && up) m_cupd = csr;
                else if (s && cp) foreach (m_cq[i]) m_cq[i] = m_cupd[i];
                if (s && cp && up) foreach (m_cq[i]) m_cq[i] = cap_core[i];
                else if (s && sh && !cp) begin
                    void'(m_cq.pop_front()); m_cq.push_back(d_out);
                end
            end
        end
        cap_core = m_cupd;
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    logic [CORE_W-1:0] cap_core = '0;
    logic [DIE_W-1:0]  old_dupd = '0;

    // Value a die shift bit takes on capture (pre-update active word)
    function automatic bit m_dupd_prev(input logic [DIE_W-1:0] dsr, input int i, input bit upd_now);
        return upd_now ? old_dupd[i] : m_dupd[i];
    endfunction

    always @(negedge clk) old_dupd = m_dupd;

    task automatic shift_bit(input bit d, input string tag);
        step(1, 1, 1, 0, 0, d, tag);
    endtask

    task automatic do_update(input string tag);
        step(1, 1, 0, 0, 1, 0, tag);
    endtask

    // Shift n bits, bit 0 first
    task automatic shift_vec(input logic [15:0] v, input int n, input string tag);
        for (int i = 0; i < n; i++) shift_bit(v[i], tag);
    endtask

    // Flush zeros, then count shifts for a single one to reach so
    task automatic measure_len(input int exp, input string tag);
        int cnt = 0;
        shift_vec(16'h0, DIE_W + CORE_W, tag);
        shift_bit(1'b1, tag);
        cnt = 1;
        while (so !== 1'b1 && cnt < 20) begin
            shift_bit(1'b0, tag);
            cnt++;
        end
        chk(cnt == exp, tag, "chain length", cnt, exp);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", WD, WD);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] v;
        for (int i = 0; i < DIE_W; i++) m_dq.push_back(0);
        for (int i = 0; i < CORE_W; i++) m_cq.push_back(0);
        @(negedge clk);
        // R1: reset state
        step(0, 0, 0, 0, 0, 0, "R1");
        step(0, 1, 1, 0, 0, 1, "R1");
        chk(die_op == 0 && !core_en && !top_byp && core_op == 0, "R1", "reset outputs", die_op, 0);
        chk(core_rst_n == 1'b0, "R1", "core_rst_n in reset", core_rst_n, 0);
        // R2: short chain length
        measure_len(DIE_W, "R2");
        // R4/R10: load opcode 0xA, bypass 1, enable 0
        shift_vec(16'h1A, DIE_W, "R4");
        do_update("R4");
        chk(die_op == 4'hA, "R4", "die_op", die_op, 4'hA);
        chk(top_byp == 1'b1, "R10", "top_byp", top_byp, 1);
        chk(core_en == 1'b0 && core_rst_n == 1'b0, "R3", "core held in reset", core_rst_n, 0);
        // R8: controls with sel_ir low have no effect
        step(1, 0, 1, 0, 0, 1, "R8");
        step(1, 0, 0, 1, 0, 0, "R8");
        step(1, 0, 0, 0, 1, 0, "R8");
        chk(die_op == 4'hA && top_byp, "R8", "die_op after deselected update", die_op, 4'hA);
        // R5: load enable=1, opcode 3; chain stays short during shift
        shift_vec(16'h23, DIE_W, "R5");
        chk(core_en == 1'b0, "R5", "core_en before update", core_en, 0);
        do_update("R5");
        chk(core_en == 1'b1 && core_rst_n == 1'b1, "R6", "core enabled", core_en, 1);
        chk(core_op == 0, "R6", "core_op after enable", core_op, 0);
        // R6: long chain length
        measure_len(DIE_W + CORE_W, "R6");
        // R6: core 5 first, then die enable=1 opcode 7
        v = {7'h0, 6'h27, 3'h5};
        shift_vec(v, DIE_W + CORE_W, "R6");
        do_update("R6");
        chk(core_op == 3'h5, "R6", "core_op", core_op, 5);
        chk(die_op == 4'h7 && !top_byp, "R6", "die_op", die_op, 7);
        // R7: capture then shift out the active words
        step(1, 1, 0, 1, 0, 0, "R7");
        v = '0;
        for (int i = 0; i < DIE_W + CORE_W; i++) begin
            v[i] = so;
            shift_bit(1'b0, "R7");
        end
        chk(v[8:0] == {6'h27, 3'h5}, "R7", "captured readback", v[8:0], {6'h27, 3'h5});
        // R7: capture and shift in the same cycle, capture wins
        step(1, 1, 1, 1, 0, 1, "R7");
        chk(so == 1'b1, "R7", "capture priority so", so, 1);
        // R9: clear enable, opcode 2
        v = {7'h0, 6'h02, 3'h6};
        shift_vec(v, DIE_W + CORE_W, "R9");
        do_update("R9");
        chk(core_en == 1'b0, "R9", "core_en cleared", core_en, 0);
        step(1, 0, 0, 0, 0, 0, "R9");
        chk(core_op == 0, "R9", "core_op cleared", core_op, 0);
        measure_len(DIE_W, "R9");
        // R3: core ignores shifting while disabled
        shift_vec(16'h1FF, DIE_W + CORE_W, "R3");
        chk(core_op == 0 && !core_rst_n, "R3", "core idle", core_op, 0);
        // R1: reset again from a loaded state
        shift_vec(16'h3F, DIE_W, "R1");
        do_update("R1");
        step(0, 0, 0, 0, 0, 0, "R1");
        step(1, 0, 0, 0, 0, 0, "R1");
        chk(die_op == 0 && !core_en && core_op == 0 && !so, "R1", "reset from loaded", die_op, 0);
        measure_len(DIE_W, "R1");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule